// File: doc/BRIEF.md
# Paired-Group Interrupt Priority Resolver

This block collects six interrupt request lines into a request register and qualifies each one with a mask bit and a global enable. From the eligible requests it picks the single winner under a programmable two-level priority. The six sources are wired into three fixed pairs. Group A holds sources 3 and 5. Group B holds sources 0 and 2. Group C holds sources 1 and 4. Three swap bits set the order inside each pair. A three-bit code picks one of six orders between the pairs. Together they give 48 distinct total orderings.

Software writes the priority, mask and request registers through a small write port. The winning source index leaves the block registered, together with a valid flag. The serviced request is cleared by pulsing `ack` with its index.

Resolution starts only after the three registers have been written in a fixed order: priority, then mask, then request. Until then the valid flag stays low.

Top module: `irq_pair_arbiter`

## Requirements
- R1: While reset is applied, and after its release until programming starts, `vec_valid` and `vec_idx` are 0, and the priority, mask and request registers are all 0.
- R2: `vec_valid` remains 0 until the registers have been written in this order: a priority write, then a later mask write, then a later request write. A request write made before the mask step, or a mask write made before the priority step, does not advance the sequence. Once armed, the block stays armed until reset.
- R3: Inside each pair, a priority bit picks the winner. Bit 5 governs pair {3,5}: 1 ranks 3 above 5, 0 ranks 5 above 3. Bit 2 governs pair {0,2}: 1 ranks 0 above 2, 0 ranks 2 above 0. Bit 1 governs pair {1,4}: 1 ranks 4 above 1, 0 ranks 1 above 4.
- R4: The pair order code is {bit4, bit3, bit0}, with A = {3,5}, B = {0,2} and C = {1,4}. The codes map as follows: 001 gives C>A>B, 010 gives A>B>C, 011 gives A>C>B, 100 gives B>C>A, 101 gives C>B>A, 110 gives B>A>C. The highest-ranked pair with any eligible request wins, and its member is then chosen by R3.
- R5: When the pair order code is 000 or 111, `vec_valid` is 0 whatever requests are pending.
- R6: A request is eligible only when its mask bit is 1 and `glob_en` is 1. With no eligible request, `vec_valid` is 0.
- R7: A request bit is set on a rising edge of its `irq_in` line. A write with `wr_sel` = 2 replaces all six request bits with `wr_data`, and this write overrides edges and acknowledges in the same cycle. `wr_sel` = 0 writes the priority register and 1 writes the mask register.
- R8: A cycle with `ack` = 1 clears the request bit numbered `ack_idx`. Values 6 and 7 of `ack_idx` clear nothing. A rising edge on the same line in the same cycle sets the bit again.
- R9: `vec_valid` and `vec_idx` are registered. They reflect the request, mask, priority and enable state one clock after that state changes. `vec_idx` is 0 whenever `vec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | 6 | Interrupt request lines; a rising edge sets the request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 priority, 1 mask, 2 request |
| wr_data | input | 6 | Register write data |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Index of the request to clear on acknowledge |
| vec_idx | output | 3 | Winning source index |
| vec_valid | output | 1 | A winner is present |

## Verification
The main function is swept exhaustively over all 48 legal priority settings against all 64 request patterns. This separates every swap-bit polarity and every pair order, because each pattern with two or more pairs pending exposes a different ranking. Random runs then mix in random masks, enable toggles and priorities, which shows that masked or disabled sources never win over lower-ranked eligible ones. Directed cases cover the reserved order codes, out-of-order programming, edge-set requests and acknowledge sequences in which clearing the winner must hand over to the next-ranked source.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int unsigned N_SRC  = 6;
  localparam int unsigned N_GRP  = 3;
  localparam int unsigned IDX_W  = $clog2(N_SRC);
  localparam int unsigned GID_W  = 2;

  typedef enum logic [1:0] {
    SEL_PRIO = 2'd0,
    SEL_MASK = 2'd1,
    SEL_REQ  = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_PRIO = 2'd1,
    ARM_MASK = 2'd2,
    ARM_LIVE = 2'd3
  } arm_step_e;

  // group ids: 0 = A {3,5}, 1 = B {0,2}, 2 = C {1,4}
  function automatic logic [IDX_W-1:0] grp_first(input int g);
    case (g)
      0:       return IDX_W'(3);
      1:       return IDX_W'(0);
      default: return IDX_W'(4);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] grp_second(input int g);
    case (g)
      0:       return IDX_W'(5);
      1:       return IDX_W'(2);
      default: return IDX_W'(1);
    endcase
  endfunction

  function automatic int grp_swap_bit(input int g);
    case (g)
      0:       return 5;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  // returns {rank0, rank1, rank2} group ids, rank0 highest
  function automatic logic [3*GID_W-1:0] grp_order(input logic [2:0] code);
    case (code)
      3'b001:  return {2'd2, 2'd0, 2'd1};
      3'b010:  return {2'd0, 2'd1, 2'd2};
      3'b011:  return {2'd0, 2'd2, 2'd1};
      3'b100:  return {2'd1, 2'd2, 2'd0};
      3'b101:  return {2'd2, 2'd1, 2'd0};
      3'b110:  return {2'd1, 2'd0, 2'd2};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned W = N_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] prio_q,
  output logic [W-1:0] mask_q,
  output logic         armed_q
);

  logic        prio_we;
  logic        mask_we;
  logic        req_we;
  arm_step_e   step_q;
  arm_step_e   step_d;

  assign prio_we = wr_en && (wr_sel == SEL_PRIO);
  assign mask_we = wr_en && (wr_sel == SEL_MASK);
  assign req_we  = wr_en && (wr_sel == SEL_REQ);

  always_comb begin
    step_d = step_q;
    case (step_q)
      ARM_IDLE: if (prio_we) step_d = ARM_PRIO;
      ARM_PRIO: if (mask_we) step_d = ARM_MASK;
      ARM_MASK: if (req_we)  step_d = ARM_LIVE;
      default:               step_d = ARM_LIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ARM_IDLE;
    end else begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (prio_we) begin
      prio_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= wr_data;
    end
  end

  assign armed_q = (step_q == ARM_LIVE);

endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_arb_pkg::*;
#(
  parameter int unsigned W  = N_SRC,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  irq_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          ack,
  input  logic [IW-1:0] ack_idx,
  output logic [W-1:0]  req_q
);

  logic [W-1:0] irq_prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] ack_clr;
  logic [W-1:0] req_d;
  logic         req_we;

  assign req_we = wr_en && (wr_sel == SEL_REQ);
  assign rise   = irq_in & ~irq_prev_q;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_clr
      assign ack_clr[i] = ack && (ack_idx == IW'(i));
    end
  endgenerate

  always_comb begin
    if (req_we) begin
      req_d = wr_data;
    end else begin
      req_d = (req_q & ~ack_clr) | rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev_q <= '0;
      req_q      <= '0;
    end else begin
      irq_prev_q <= irq_in;
      req_q      <= req_d;
    end
  end

endmodule

// File: rtl/irq_pair_rank.sv
module irq_pair_rank
  import irq_arb_pkg::*;
#(
  parameter int unsigned W  = N_SRC,
  parameter int unsigned NG = N_GRP,
  parameter int unsigned IW = IDX_W
) (
  input  logic [W-1:0]  elig,
  input  logic [W-1:0]  prio,
  output logic          hit,
  output logic [IW-1:0] idx
);

  localparam int unsigned NG_P = 1 << GID_W;

  logic [NG_P-1:0] grp_any;
  logic [IW-1:0]   grp_pick [NG_P];
  logic [2:0]      code;
  logic            code_ok;
  logic [3*GID_W-1:0] order;

  genvar g;
  generate
    for (g = 0; g < NG_P; g++) begin : g_grp
      if (g < NG) begin : g_real
        localparam logic [IW-1:0] FIRST  = grp_first(g);
        localparam logic [IW-1:0] SECOND = grp_second(g);
        localparam int            SWAP   = grp_swap_bit(g);
        logic first_on;
        logic second_on;
        assign first_on    = elig[FIRST];
        assign second_on   = elig[SECOND];
        assign grp_any[g]  = first_on | second_on;
        assign grp_pick[g] = prio[SWAP] ? (first_on ? FIRST : SECOND)
                                        : (second_on ? SECOND : FIRST);
      end else begin : g_pad
        assign grp_any[g]  = 1'b0;
        assign grp_pick[g] = '0;
      end
    end
  endgenerate

  assign code    = {prio[4], prio[3], prio[0]};
  assign code_ok = (code != 3'b000) && (code != 3'b111);
  assign order   = grp_order(code);

  always_comb begin
    logic          found;
    logic [IW-1:0] pick;
    found = 1'b0;
    pick  = '0;
    for (int r = NG - 1; r >= 0; r--) begin
      logic [GID_W-1:0] gid;
      gid = order[(3 - r) * GID_W - 1 -: GID_W];
      if (grp_any[gid]) begin
        found = 1'b1;
        pick  = grp_pick[gid];
      end
    end
    hit = found && code_ok;
    idx = (found && code_ok) ? pick : '0;
  end

endmodule

// File: rtl/irq_pair_arbiter.sv
module irq_pair_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned W  = N_SRC,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  irq_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          glob_en,
  input  logic          ack,
  input  logic [IW-1:0] ack_idx,
  output logic [IW-1:0] vec_idx,
  output logic          vec_valid
);

  logic          rst_meta_q;
  logic          rst_sync_n;
  logic [W-1:0]  prio_q;
  logic [W-1:0]  mask_q;
  logic [W-1:0]  req_q;
  logic          armed_q;
  logic [W-1:0]  elig;
  logic          hit;
  logic [IW-1:0] pick;
  logic          valid_d;
  logic [IW-1:0] idx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  irq_cfg_regs #(.W(W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .prio_q  (prio_q),
    .mask_q  (mask_q),
    .armed_q (armed_q)
  );

  irq_req_bank #(.W(W), .IW(IW)) u_req (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .irq_in  (irq_in),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ack     (ack),
    .ack_idx (ack_idx),
    .req_q   (req_q)
  );

  assign elig = req_q & mask_q & {W{glob_en}};

  irq_pair_rank #(.W(W), .IW(IW)) u_rank (
    .elig (elig),
    .prio (prio_q),
    .hit  (hit),
    .idx  (pick)
  );

  always_comb begin
    valid_d = hit && armed_q;
    idx_d   = valid_d ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_valid <= 1'b0;
      vec_idx   <= '0;
    end else begin
      vec_valid <= valid_d;
      vec_idx   <= idx_d;
    end
  end

endmodule

// File: rtl/irq_pair_arbiter_chk.sv
module irq_pair_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_in,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             glob_en,
  input logic             ack,
  input logic [IDX_W-1:0] ack_idx,
  input logic [N_SRC-1:0] req_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] prio_q,
  input logic             armed_q,
  input logic [IDX_W-1:0] vec_idx,
  input logic             vec_valid
);

  logic [N_SRC-1:0] elig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_d <= '0;
    end else begin
      elig_d <= req_q & mask_q & {N_SRC{glob_en}};
    end
  end

  AST_VALID_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_idx < IDX_W'(N_SRC)) && elig_d[vec_idx]); // R6

  AST_RESERVED_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past({prio_q[4], prio_q[3], prio_q[0]}) == 3'b000 ||
     $past({prio_q[4], prio_q[3], prio_q[0]}) == 3'b111) |-> !vec_valid); // R5

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(armed_q) |-> !vec_valid); // R2

  AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_idx < IDX_W'(N_SRC) && !(wr_en && wr_sel == SEL_REQ) &&
     !irq_in[ack_idx]) |=> !req_q[$past(ack_idx)]); // R8

  AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vec_idx == '0); // R9

endmodule

bind irq_pair_arbiter irq_pair_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_in    (irq_in),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .glob_en   (glob_en),
  .ack       (ack),
  .ack_idx   (ack_idx),
  .req_q     (req_q),
  .mask_q    (mask_q),
  .prio_q    (prio_q),
  .armed_q   (armed_q),
  .vec_idx   (vec_idx),
  .vec_valid (vec_valid)
);

// File: tb/irq_pair_arbiter_test.sv
module irq_pair_arbiter_test;

  localparam int PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [5:0] irq_in;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [5:0] wr_data;
  logic       glob_en;
  logic       ack;
  logic [2:0] ack_idx;
  logic [2:0] vec_idx;
  logic       vec_valid;

  int checks;
  int errors;
  bit done;

  irq_pair_arbiter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .glob_en   (glob_en),
    .ack       (ack),
    .ack_idx   (ack_idx),
    .vec_idx   (vec_idx),
    .vec_valid (vec_valid)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  // reference: rank = pair rank * 2 + member rank, lowest wins; -1 when none
  function automatic int ref_pick(input logic [5:0] p, input logic [5:0] e);
    logic [2:0] code;
    int gr [3];
    int best;
    int best_rank;
    code = {p[4], p[3], p[0]};
    case (code)
      3'b001: begin gr[0] = 1; gr[1] = 2; gr[2] = 0; end
      3'b010: begin gr[0] = 0; gr[1] = 1; gr[2] = 2; end
      3'b011: begin gr[0] = 0; gr[1] = 2; gr[2] = 1; end
      3'b100: begin gr[0] = 2; gr[1] = 0; gr[2] = 1; end
      3'b101: begin gr[0] = 2; gr[1] = 1; gr[2] = 0; end
      3'b110: begin gr[0] = 1; gr[1] = 0; gr[2] = 2; end
      default: return -1;
    endcase
    best = -1;
    best_rank = 99;
    for (int i = 0; i < 6; i++) begin
      int g;
      int m;
      int rk;
      if (i == 3 || i == 5) begin
        g = 0; m = ((i == 3) == p[5]) ? 0 : 1;
      end else if (i == 0 || i == 2) begin
        g = 1; m = ((i == 0) == p[2]) ? 0 : 1;
      end else begin
        g = 2; m = ((i == 4) == p[1]) ? 0 : 1;
      end
      rk = gr[g] * 2 + m;
      if (e[i] && rk < best_rank) begin
        best_rank = rk;
        best = i;
      end
    end
    return best;
  endfunction

  function automatic logic [5:0] mk_prio(input logic [2:0] code, input logic [2:0] sw);
    return {sw[2], code[2], code[1], sw[1], sw[0], code[0]};
  endfunction

  task automatic expect_out(input int exp_idx, input string req);
    logic       ev;
    logic [2:0] ei;
    ev = (exp_idx >= 0);
    ei = ev ? 3'(exp_idx) : 3'd0;
    checks++;
    if (vec_valid !== ev || vec_idx !== ei) begin
      errors++;
      $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
               req, vec_valid, vec_idx, ev, ei);
    end
  endtask

  // write lands on the next posedge; returns at the negedge after it
  task automatic wr(input logic [1:0] sel, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    irq_in = '0; wr_en = 0; wr_sel = 0; wr_data = 0;
    glob_en = 0; ack = 0; ack_idx = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    expect_out(-1, "R1 during reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    expect_out(-1, "R1 after reset");

    // out-of-order programming must not arm (R2)
    glob_en = 1;
    wr(2'd1, 6'h3F);
    wr(2'd0, mk_prio(3'b010, 3'b111));
    wr(2'd2, 6'h3F);
    settle();
    expect_out(-1, "R2 request before mask step");
    wr(2'd1, 6'h3F);
    settle();
    expect_out(-1, "R2 mask step alone");
    wr(2'd2, 6'h3F);
    settle();
    expect_out(ref_pick(mk_prio(3'b010, 3'b111), 6'h3F), "R2 armed after ordered writes");

    // exhaustive sweep: 48 priorities x 64 patterns (R3 R4 R9)
    for (int c = 1; c <= 6; c++) begin
      for (int s = 0; s < 8; s++) begin
        logic [5:0] p;
        p = mk_prio(3'(c), 3'(s));
        wr(2'd0, p);
        for (int pat = 0; pat < 64; pat++) begin
          wr(2'd2, 6'(pat));
          settle();
          expect_out(ref_pick(p, 6'(pat)), "R3 R4 sweep");
        end
      end
    end

    // reserved codes (R5)
    wr(2'd0, mk_prio(3'b000, 3'b101));
    wr(2'd2, 6'h3F);
    settle();
    expect_out(-1, "R5 code 000");
    wr(2'd0, mk_prio(3'b111, 3'b010));
    settle();
    expect_out(-1, "R5 code 111");

    // enable and mask (R6)
    wr(2'd0, mk_prio(3'b010, 3'b000));
    @(negedge clk); glob_en = 0;
    settle();
    expect_out(-1, "R6 global enable off");
    @(negedge clk); glob_en = 1;
    settle();
    expect_out(ref_pick(mk_prio(3'b010, 3'b000), 6'h3F), "R6 enable back on");
    wr(2'd1, 6'b010000);
    wr(2'd2, 6'b101111);
    settle();
    expect_out(-1, "R6 only masked requests");

    // edge set (R7)
    wr(2'd1, 6'h3F);
    wr(2'd2, 6'h00);
    settle();
    expect_out(-1, "R7 cleared by write");
    @(negedge clk); irq_in = 6'b010000;
    @(negedge clk); irq_in = 6'b000000;
    settle();
    expect_out(4, "R7 rising edge sets request");
    @(negedge clk); irq_in = 6'b000100;
    @(negedge clk);
    settle();
    expect_out(ref_pick(mk_prio(3'b010, 3'b000), 6'b010100), "R7 second edge");
    @(negedge clk); irq_in = 6'b000000;

    // acknowledge hand-over (R8): prio code 010 A>B>C, swaps 0 -> 5,3,2,0,1,4
    wr(2'd2, 6'b101101);
    settle();
    expect_out(5, "R8 before ack");
    @(negedge clk); ack = 1; ack_idx = 3'd5;
    @(negedge clk); ack = 0;
    settle();
    expect_out(3, "R8 ack clears winner");
    @(negedge clk); ack = 1; ack_idx = 3'd6;
    @(negedge clk); ack = 0;
    settle();
    expect_out(3, "R8 index 6 clears nothing");
    @(negedge clk); ack = 1; ack_idx = 3'd3;
    @(negedge clk); ack = 0; ack_idx = 3'd2;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    settle();
    expect_out(0, "R8 chained acks");

    // random mix (R3 R4 R6)
    for (int k = 0; k < 400; k++) begin
      logic [5:0] p;
      logic [5:0] m;
      logic [5:0] r;
      logic       en;
      p  = mk_prio(3'(1 + ($urandom % 6)), 3'($urandom));
      m  = 6'($urandom);
      r  = 6'($urandom);
      en = ($urandom % 4) != 0;
      wr(2'd0, p);
      wr(2'd1, m);
      glob_en = en;
      wr(2'd2, r);
      settle();
      expect_out(ref_pick(p, r & m & {6{en}}), "R6 random mix");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule